// File: doc/BRIEF.md
# SDRAM Command and Status Register

This block is a 32-bit register that a host uses to steer an attached synchronous DRAM through start-up and power management. Three low bits are commands: exit self refresh (bit 0), enter self refresh (bit 1) and run the power-on initialization sequence (bit 2). Writing one of them hands a one-cycle start pulse to a downstream pin sequencer. The bit stays set while that operation runs and clears itself when the sequencer returns a one-cycle done pulse. Software polls the low bits to learn that the operation has completed.

A 16-bit field in bits 23..8 holds the mode-register word. The sequencer drives this word onto DRAM address lines A15..A0 while it loads the mode register during power-on. Within the word, bits 14..12 give the CAS latency (2 or 3), bit 11 must be 0 for sequential burst order, bits 10..8 give the burst length (1 or 2), and bits 23..15 are kept at zero. Two status bits show whether power-on initialization is still pending (bit 5) and whether the DRAM is in self refresh (bit 4).

The block refuses three kinds of command write and raises a sticky error output for two of them: a write that sets more than one command bit, and a power-on command given while self refresh is still in effect. When the controller is not in SDRAM mode, only the mode-word field takes writes.

Top module: `sdram_ctl_csr`

## Requirements
- R1: After a synchronous reset, rd_data reads 0x00003030, so the mode word is 0x0030 and bits 5 and 4 both read 1. seq_start and cmd_err read 0.
- R2: In SDRAM mode, while no command is busy, a write with exactly one of bits 2..0 set and an allowed command makes that bit read 1 from the next cycle on. seq_start shows the same one-hot value for exactly that one cycle.
- R3: A seq_done pulse while a command bit is set clears that bit on the next cycle. Completion of exit self refresh (bit 0) clears status bit 4. Completion of enter self refresh (bit 1) sets bit 4. Completion of power-on (bit 2) clears bit 5.
- R4: A write with two or more of bits 2..0 set starts nothing and leaves bits 2..0 at 0. It sets cmd_err on the next cycle.
- R5: A power-on command (bit 2) written while bit 4 reads 1 is not forwarded to the sequencer. Bit 2 reads 0 and cmd_err is set on the next cycle.
- R6: With sdram_mode low, a write changes neither the command bits nor seq_start nor cmd_err, but it still updates bits 23..8.
- R7: Every write updates bits 23..8 on the next cycle, and mode_word always equals the value of those bits.
- R8: Bits 31..24, 7..6 and 3 always read 0, whatever has been written to them.
- R9: While a command bit is set, a write changes no command bit and produces no start pulse, but bits 23..8 still take the written value.
- R10: A seq_done pulse while no command is busy changes no bit of rd_data.
- R11: Once set, cmd_err stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sdram_mode | input | 1 | High when the controller is configured for SDRAM |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read view |
| seq_start | output | 3 | One-cycle start pulse to the sequencer, one-hot by command |
| seq_done | input | 1 | One-cycle completion pulse from the sequencer |
| mode_word | output | 16 | Mode-register word for DRAM address lines A15..A0 |
| cmd_err | output | 1 | Sticky flag for a refused command write |

## Verification
The bench builds the block with the package defaults: a 32-bit register, a 16-bit mode field at bit 8, three commands and a reset mode word of 0x0030. These values bring the exact reset image 0x00003030 and the full one-hot command set within reach. A behavioural model tracks the register on every clock. The stimulus includes a refused power-on while self refresh is active, writes that collide with a busy command, done pulses that arrive while no command is busy, and writes in non-SDRAM mode that only change the field.

// File: rtl/sdcsr_pkg.sv
package sdcsr_pkg;
    localparam int REG_W     = 32;
    localparam int FIELD_LSB = 8;
    localparam int FIELD_W   = 16;
    localparam int NCMD      = 3;
    localparam int FIELD_MSB = FIELD_LSB + FIELD_W - 1;

    // command bit positions (software-visible ordering)
    localparam int CMD_EXIT_SR  = 0;
    localparam int CMD_ENTER_SR = 1;
    localparam int CMD_POR      = 2;

    // status bit positions
    localparam int ST_SR_BIT  = 4;
    localparam int ST_POR_BIT = 5;

    localparam logic [FIELD_W-1:0] FIELD_RST = 16'h0030;

    typedef logic [NCMD-1:0]    cmd_vec_t;
    typedef logic [FIELD_W-1:0] field_t;

    typedef struct packed {
        logic     take;
        logic     reject;
        cmd_vec_t cmd;
    } wr_dec_t;

    typedef struct packed {
        logic por_pending;
        logic self_refresh;
    } dram_stat_t;

    function automatic logic multi_hot(input cmd_vec_t v);
        return (v & (v - cmd_vec_t'(1))) != '0;
    endfunction

    function automatic logic [REG_W-1:0] pack_view(input field_t f,
                                                    input dram_stat_t s,
                                                    input cmd_vec_t c);
        logic [REG_W-1:0] r;
        r = '0;
        r[FIELD_MSB:FIELD_LSB] = f;
        r[ST_POR_BIT]          = s.por_pending;
        r[ST_SR_BIT]           = s.self_refresh;
        r[NCMD-1:0]            = c;
        return r;
    endfunction
endpackage

// File: rtl/sdcsr_wr_decode.sv
module sdcsr_wr_decode
    import sdcsr_pkg::*;
(
    input  logic     wr_en,
    input  logic     sdram_mode,
    input  logic     busy,
    input  logic     self_refresh,
    input  cmd_vec_t wr_cmd,
    output wr_dec_t  dec
);
    always_comb begin
        dec = '0;
        if (wr_en && sdram_mode && !busy && (wr_cmd != '0)) begin
            if (multi_hot(wr_cmd) || (wr_cmd[CMD_POR] && self_refresh)) begin
                dec.reject = 1'b1;
            end else begin
                dec.take = 1'b1;
                dec.cmd  = wr_cmd;
            end
        end
    end
endmodule

// File: rtl/sdcsr_cmd_engine.sv
module sdcsr_cmd_engine
    import sdcsr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  wr_dec_t    dec,
    input  logic       seq_done,
    output cmd_vec_t   cmd_q,
    output cmd_vec_t   start_q,
    output dram_stat_t stat_q,
    output logic       err_q,
    output logic       busy
);
    assign busy = |cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= '0;
            start_q <= '0;
            stat_q  <= '{por_pending: 1'b1, self_refresh: 1'b1};
            err_q   <= 1'b0;
        end else begin
            start_q <= dec.take ? dec.cmd : '0;
            if (dec.reject) err_q <= 1'b1;
            if (busy && seq_done) begin
                cmd_q <= '0;
                if (cmd_q[CMD_EXIT_SR])  stat_q.self_refresh <= 1'b0;
                if (cmd_q[CMD_ENTER_SR]) stat_q.self_refresh <= 1'b1;
                if (cmd_q[CMD_POR])      stat_q.por_pending  <= 1'b0;
            end else if (dec.take) begin
                cmd_q <= dec.cmd;
            end
        end
    end

    a_r2_start_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(start_q));
    a_r2_start_shown: assert property (@(posedge clk) disable iff (rst)
        (start_q != '0) |-> (cmd_q == start_q));
    a_r3_clear_on_done: assert property (@(posedge clk) disable iff (rst)
        (busy && seq_done) |=> (cmd_q == '0));
    a_r3_por_done_only: assert property (@(posedge clk) disable iff (rst)
        $fell(stat_q.por_pending) |-> $past(cmd_q[CMD_POR] && seq_done));
    a_r5_por_after_exit: assert property (@(posedge clk) disable iff (rst)
        start_q[CMD_POR] |-> !stat_q.self_refresh);
    a_r9_hold_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && !seq_done) |=> $stable(cmd_q));
    a_r11_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);
endmodule

// File: rtl/sdcsr_field_reg.sv
module sdcsr_field_reg #(
    parameter int              W   = 16,
    parameter logic [W-1:0]    RST = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    output logic [W-1:0] val_q
);
    always_ff @(posedge clk) begin
        if (rst)        val_q <= RST;
        else if (wr_en) val_q <= wr_val;
    end

    a_r7_field_follows: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (val_q == $past(wr_val)));
endmodule

// File: rtl/sdram_ctl_csr.sv
module sdram_ctl_csr
    import sdcsr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                sdram_mode,
    input  logic                wr_en,
    input  logic [REG_W-1:0]    wr_data,
    output logic [REG_W-1:0]    rd_data,
    output logic [NCMD-1:0]     seq_start,
    input  logic                seq_done,
    output logic [FIELD_W-1:0]  mode_word,
    output logic                cmd_err
);
    wr_dec_t    dec;
    cmd_vec_t   cmd_q;
    cmd_vec_t   start_q;
    dram_stat_t stat_q;
    logic       busy;
    field_t     field_q;

    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[REG_W-1:FIELD_MSB+1], wr_data[FIELD_LSB-1:NCMD]};

    sdcsr_wr_decode u_dec (
        .wr_en        (wr_en),
        .sdram_mode   (sdram_mode),
        .busy         (busy),
        .self_refresh (stat_q.self_refresh),
        .wr_cmd       (wr_data[NCMD-1:0]),
        .dec          (dec)
    );

    sdcsr_cmd_engine u_eng (
        .clk      (clk),
        .rst      (rst),
        .dec      (dec),
        .seq_done (seq_done),
        .cmd_q    (cmd_q),
        .start_q  (start_q),
        .stat_q   (stat_q),
        .err_q    (cmd_err),
        .busy     (busy)
    );

    sdcsr_field_reg #(.W(FIELD_W), .RST(FIELD_RST)) u_fld (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_val (wr_data[FIELD_MSB:FIELD_LSB]),
        .val_q  (field_q)
    );

    assign rd_data   = pack_view(field_q, stat_q, cmd_q);
    assign seq_start = start_q;
    assign mode_word = field_q;

    a_r6_mode_gate: assert property (@(posedge clk) disable iff (rst)
        (!sdram_mode && !busy) |=> (seq_start == '0));
    a_r10_idle_done: assert property (@(posedge clk) disable iff (rst)
        (!busy && seq_done && !wr_en) |=> $stable(rd_data));
endmodule

// File: tb/sim_sdram_ctl_csr.sv
module sim_sdram_ctl_csr;
    logic        clk = 1'b0;
    logic        rst, sdram_mode, wr_en, seq_done;
    logic [31:0] wr_data, rd_data;
    logic [2:0]  seq_start;
    logic [15:0] mode_word;
    logic        cmd_err;

    int checks = 0, failures = 0;
    bit finished = 0;

    // behavioural model state
    logic [15:0] m_field;
    logic [2:0]  m_cmd, m_start;
    logic        m_por, m_sr, m_err;

    always #10 clk = ~clk;

    sdram_ctl_csr u0 (
        .clk(clk), .rst(rst), .sdram_mode(sdram_mode), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .seq_start(seq_start),
        .seq_done(seq_done), .mode_word(mode_word), .cmd_err(cmd_err)
    );

    task automatic step(input logic r, input logic m, input logic we,
                        input logic [31:0] d, input logic dn, input string tag);
        logic [15:0] nf; logic [2:0] nc, ns; logic np, nsr, ne;
        logic [31:0] exp_rd; int ones;
        rst = r; sdram_mode = m; wr_en = we; wr_data = d; seq_done = dn;
        nf = m_field; nc = m_cmd; ns = 3'b000; np = m_por; nsr = m_sr; ne = m_err;
        if (r) begin
            nf = 16'h0030; nc = 0; np = 1; nsr = 1; ne = 0;
        end else begin
            if (dn && m_cmd != 0) begin
                if (m_cmd == 3'b001) nsr = 0;
                if (m_cmd == 3'b010) nsr = 1;
                if (m_cmd == 3'b100) np = 0;
                nc = 0;
            end
            if (we) begin
                nf = d[23:8];
                if (m && m_cmd == 0 && d[2:0] != 0) begin
                    ones = int'(d[0]) + int'(d[1]) + int'(d[2]);
                    if (ones > 1 || (d[2] && m_sr)) ne = 1;
                    else begin nc = d[2:0]; ns = d[2:0]; end
                end
            end
        end
        @(posedge clk);
        m_field = nf; m_cmd = nc; m_start = ns; m_por = np; m_sr = nsr; m_err = ne;
        @(negedge clk);
        exp_rd = {8'h00, m_field, 2'b00, m_por, m_sr, 1'b0, m_cmd};
        checks++;
        if (rd_data !== exp_rd || seq_start !== m_start || mode_word !== m_field
            || cmd_err !== m_err) begin
            failures++;
            $display("FAIL %s: rd=%h start=%b mw=%h err=%b expected rd=%h start=%b mw=%h err=%b",
                     tag, rd_data, seq_start, mode_word, cmd_err,
                     exp_rd, m_start, m_field, m_err);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        m_field = 0; m_cmd = 0; m_start = 0; m_por = 0; m_sr = 0; m_err = 0;
        rst = 1; sdram_mode = 1; wr_en = 0; wr_data = 0; seq_done = 0;
        @(negedge clk);
        step(1, 1, 0, 0, 0, "R1 reset");
        step(0, 1, 0, 0, 0, "R1 reset value");
        // R8 reserved bits ignored, R7 field written
        step(0, 1, 1, 32'hFF0232C8, 0, "R8 R7 reserved/field");
        // R5 power-on refused while in self refresh, R11 sticky
        step(0, 1, 1, 32'h00033004, 0, "R5 por refused");
        step(0, 1, 0, 0, 0, "R11 err sticky");
        step(0, 1, 0, 0, 1, "R10 done while idle");
        // R2 exit self refresh, R3 completion
        step(0, 1, 1, 32'h00033001, 0, "R2 exit sr start");
        step(0, 1, 0, 0, 0, "R2 start one cycle");
        step(0, 1, 0, 0, 1, "R3 exit done");
        step(0, 1, 0, 0, 0, "R3 sr cleared");
        // power-on now allowed; R9 writes while busy
        step(0, 1, 1, 32'h00032204, 0, "R2 por start");
        step(0, 1, 1, 32'h00023102, 0, "R9 write busy");
        step(0, 1, 1, 32'h00003003, 0, "R9 multi write busy");
        step(0, 1, 0, 0, 1, "R3 por done");
        step(0, 1, 0, 0, 1, "R10 extra done");
        // enter self refresh
        step(0, 1, 1, 32'h00003002, 0, "R2 enter sr start");
        step(0, 1, 1, 32'h00003001, 1, "R9 R3 done with write");
        step(0, 1, 0, 0, 0, "R3 sr set");
        // R6 non-SDRAM mode
        step(0, 0, 1, 32'h00ABCD01, 0, "R6 mode off write");
        step(0, 0, 1, 32'h00123404, 0, "R6 mode off por");
        step(0, 0, 0, 0, 0, "R6 no start");
        // R4 multi-bit rejection after fresh reset
        step(1, 1, 0, 0, 0, "R1 reset again");
        step(0, 1, 1, 32'h00003003, 0, "R4 multi 011");
        step(0, 1, 0, 0, 0, "R4 nothing busy");
        step(1, 1, 0, 0, 0, "R1 reset");
        step(0, 1, 1, 32'h00003006, 0, "R4 multi 110");
        step(0, 1, 1, 32'h00003001, 0, "R2 exit after err");
        step(0, 1, 0, 0, 1, "R11 err kept");
        step(0, 1, 0, 0, 0, "R8 final");
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule